// File: doc/BRIEF.md
# Parallel LCD bus bridge

This block connects a memory-mapped register bus to the 8080-style parallel bus of a small LCD controller. Software sees three word registers in a four-word window. A write to the command word or the data word becomes a write cycle on the parallel bus, with the register-select line marking which one it is. A read of the data word starts a read cycle on the parallel bus. That same register read returns the value captured by the previous read cycle.

Read cycles complete in the background. When the parallel read strobe rises, the returned value is latched and a completion flag is set. Software polls the flag and then clears it by writing 0. Reading the command word does not start a cycle. It returns whether the bridge is still working. The register side never waits. One request can be parked while a parallel cycle runs, and a request that finds the parked slot full is discarded.

Word index decoding is: 0 = command/busy, 1 = data, 2 = status, 3 = unused.

Top module: `lcd_bus_bridge`

## Requirements
- R1: After reset `cs_no`, `wr_no` and `rd_no` are 1 and `db_oe_o` is 0. Reads of word 0 and word 2 return 0.
- R2: A write to word 0 produces one parallel write cycle with `rs_o` = 0. During that cycle `db_o` equals `wdata_i`.
- R3: A write to word 1 produces one parallel write cycle with `rs_o` = 1. During that cycle `db_o` equals `wdata_i`.
- R4: The timing of every parallel cycle is as follows.
  - `cs_no` is low for one clock before the strobe falls.
  - The strobe (`wr_no` or `rd_no`) stays low for exactly STROBE_CLKS clocks. The two strobes are never low together.
  - After the strobe rises, `cs_no` stays low for exactly HOLD_CLKS clocks. In a write, `db_oe_o` stays 1 and `db_o` stays unchanged through those clocks.
  - `cs_no` returns high between consecutive cycles.
- R5: A read of word 1 produces one parallel read cycle with `rs_o` = 1 and `db_oe_o` = 0. `db_i` is captured at the clock edge on which `rd_no` rises. A later read of word 1 returns the captured value in bits [DB_W-1:0], with zero above.
- R6: The completion flag is set on the same edge as the capture. A read of word 2 returns the flag in bit 0 and zero in bits [31:1].
- R7: Writing word 2 with `wdata_i[0]` = 0 clears the flag. Writing it with bit 0 = 1 leaves the flag unchanged. A capture on the same edge as a clear leaves the flag set.
- R8: A read of word 0 returns 1 in bit 0 while a parallel cycle runs or a request is parked. Bits [31:1] are zero. The read starts no parallel cycle.
- R9: Requests are accepted every clock with no stall. One request is parked while a cycle runs, and parked requests are served in arrival order. A request that arrives while the parked slot is full and not being released in that clock is discarded.
- R10: Reads of word 3 return 0. Writes to word 3 start no parallel cycle and leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access this clock |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 2 | Word index of the register |
| wdata_i | input | DB_W | Write data |
| rdata_o | output | 32 | Read data, combinational on the request clock |
| cs_no | output | 1 | Parallel chip select, active low |
| rs_o | output | 1 | Register select: 0 command, 1 data |
| wr_no | output | 1 | Write strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| db_o | output | DB_W | Parallel data out |
| db_oe_o | output | 1 | Drive enable for `db_o` |
| db_i | input | DB_W | Parallel data in |

## Verification
The bench sets STROBE_CLKS = 3 and HOLD_CLKS = 2, so the strobe width and the hold length can be told apart from each other and from the one-clock setup. A bus monitor measures each strobe width, setup and hold window directly at the pins. The bench sweeps walking-one and walking-zero patterns over both write ports and a set of read values over the data port. A three-request burst fills the parked slot and shows the discard.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;
  typedef enum logic [1:0] {
    OP_CMD_WR = 2'd0,
    OP_DAT_WR = 2'd1,
    OP_DAT_RD = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    W_CMD  = 2'd0,
    W_DATA = 2'd1,
    W_STAT = 2'd2,
    W_NONE = 2'd3
  } word_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SETUP  = 2'd1,
    S_STROBE = 2'd2,
    S_HOLD   = 2'd3
  } st_e;
endpackage

// File: rtl/lcdb_engine.sv
module lcdb_engine
  import lcdb_pkg::*;
#(
  parameter int DB_W        = 16,
  parameter int STROBE_CLKS = 4,
  parameter int HOLD_CLKS   = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            job_valid_i,
  input  op_e             job_op_i,
  input  logic [DB_W-1:0] job_data_i,
  output logic            launch_o,
  output logic            active_o,
  output logic            cap_o,
  output logic [DB_W-1:0] cap_data_o,
  output logic            cs_no,
  output logic            rs_o,
  output logic            wr_no,
  output logic            rd_no,
  output logic [DB_W-1:0] db_o,
  output logic            db_oe_o,
  input  logic [DB_W-1:0] db_i
);
  localparam int MAXC  = (STROBE_CLKS > HOLD_CLKS) ? STROBE_CLKS : HOLD_CLKS;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] STR_LAST = CNT_W'(STROBE_CLKS - 1);
  localparam logic [CNT_W-1:0] HLD_LAST = CNT_W'(HOLD_CLKS - 1);

  st_e             st_q, st_d;
  op_e             op_q;
  logic [DB_W-1:0] data_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            is_rd;

  assign is_rd    = (op_q == OP_DAT_RD);
  assign launch_o = (st_q == S_IDLE) && job_valid_i;
  assign active_o = (st_q != S_IDLE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE:   if (job_valid_i) st_d = S_SETUP;
      S_SETUP: begin
        st_d  = S_STROBE;
        cnt_d = '0;
      end
      S_STROBE: begin
        if (cnt_q == STR_LAST) begin
          st_d  = S_HOLD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_HOLD: begin
        if (cnt_q == HLD_LAST) st_d = S_IDLE;
        else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      op_q   <= OP_CMD_WR;
      data_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (launch_o) begin
        op_q   <= job_op_i;
        data_q <= job_data_i;
      end
    end
  end

  // capture on the edge that ends the read strobe
  assign cap_o      = (st_q == S_STROBE) && (cnt_q == STR_LAST) && is_rd;
  assign cap_data_o = db_i;

  assign cs_no   = (st_q == S_IDLE);
  assign rs_o    = (op_q != OP_CMD_WR);
  assign wr_no   = !((st_q == S_STROBE) && !is_rd);
  assign rd_no   = !((st_q == S_STROBE) && is_rd);
  assign db_oe_o = (st_q != S_IDLE) && !is_rd;
  assign db_o    = data_q;

  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!wr_no && !rd_no));
  p_cs_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no || !rd_no) |-> !cs_no);
  p_hold_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!wr_no) && wr_no && !cs_no) |-> $stable(db_o) && db_oe_o);
  p_oe_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !db_oe_o);
  p_launch_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !cs_no && wr_no && rd_no);
endmodule

// File: rtl/lcdb_regif.sv
module lcdb_regif
  import lcdb_pkg::*;
#(
  parameter int DB_W  = 16,
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       word_i,
  input  logic [DB_W-1:0]  wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             launch_i,
  input  logic             active_i,
  input  logic             cap_i,
  input  logic [DB_W-1:0]  cap_data_i,
  output logic             job_valid_o,
  output op_e              job_op_o,
  output logic [DB_W-1:0]  job_data_o
);
  word_e           sel;
  logic            queue_req, take, clr;
  op_e             req_op;
  logic            pend_q;
  op_e             pend_op_q;
  logic [DB_W-1:0] pend_data_q;
  logic            done_q;
  logic [DB_W-1:0] rd_data_q;
  logic            busy;

  assign sel = word_e'(word_i);

  always_comb begin
    queue_req = 1'b0;
    req_op    = OP_CMD_WR;
    if (req_i) begin
      if (sel == W_CMD && we_i) begin
        queue_req = 1'b1;
        req_op    = OP_CMD_WR;
      end else if (sel == W_DATA) begin
        queue_req = 1'b1;
        req_op    = we_i ? OP_DAT_WR : OP_DAT_RD;
      end
    end
  end

  assign take = queue_req && (!pend_q || launch_i);
  assign clr  = req_i && we_i && (sel == W_STAT) && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_op_q   <= OP_CMD_WR;
      pend_data_q <= '0;
    end else begin
      if (launch_i) pend_q <= 1'b0;
      if (take) begin
        pend_q      <= 1'b1;
        pend_op_q   <= req_op;
        pend_data_q <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      rd_data_q <= '0;
    end else begin
      if (cap_i) begin
        done_q    <= 1'b1;
        rd_data_q <= cap_data_i;
      end else if (clr) begin
        done_q <= 1'b0;
      end
    end
  end

  assign job_valid_o = pend_q;
  assign job_op_o    = pend_op_q;
  assign job_data_o  = pend_data_q;
  assign busy        = active_i || pend_q;

  always_comb begin
    unique case (sel)
      W_CMD:   rdata_o = {{(REG_W-1){1'b0}}, busy};
      W_DATA:  rdata_o = {{(REG_W-DB_W){1'b0}}, rd_data_q};
      W_STAT:  rdata_o = {{(REG_W-1){1'b0}}, done_q};
      default: rdata_o = '0;
    endcase
  end

  p_flag_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> done_q);
  p_flag_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !cap_i) |=> !done_q);
  p_flag_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !clr) |=> $stable(done_q));
  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !launch_i) |=> pend_q && $stable(pend_data_q));
endmodule

// File: rtl/lcd_bus_bridge.sv
module lcd_bus_bridge
  import lcdb_pkg::*;
#(
  parameter int DB_W        = 16,
  parameter int STROBE_CLKS = 4,
  parameter int HOLD_CLKS   = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [1:0]      word_i,
  input  logic [DB_W-1:0] wdata_i,
  output logic [31:0]     rdata_o,
  output logic            cs_no,
  output logic            rs_o,
  output logic            wr_no,
  output logic            rd_no,
  output logic [DB_W-1:0] db_o,
  output logic            db_oe_o,
  input  logic [DB_W-1:0] db_i
);
  localparam int REG_W = 32;

  logic            job_valid, launch, active, cap;
  op_e             job_op;
  logic [DB_W-1:0] job_data, cap_data;

  lcdb_regif #(.DB_W(DB_W), .REG_W(REG_W)) u_regif (
    .clk_i, .rst_ni, .req_i, .we_i, .word_i, .wdata_i, .rdata_o,
    .launch_i(launch), .active_i(active), .cap_i(cap), .cap_data_i(cap_data),
    .job_valid_o(job_valid), .job_op_o(job_op), .job_data_o(job_data)
  );

  lcdb_engine #(.DB_W(DB_W), .STROBE_CLKS(STROBE_CLKS), .HOLD_CLKS(HOLD_CLKS)) u_engine (
    .clk_i, .rst_ni,
    .job_valid_i(job_valid), .job_op_i(job_op), .job_data_i(job_data),
    .launch_o(launch), .active_o(active), .cap_o(cap), .cap_data_o(cap_data),
    .cs_no, .rs_o, .wr_no, .rd_no, .db_o, .db_oe_o, .db_i
  );

  initial begin
    a_params_r4: assert (STROBE_CLKS >= 1 && HOLD_CLKS >= 1 && DB_W <= REG_W);
  end
endmodule

// File: tb/tb_lcd_bus_bridge.sv
module tb_lcd_bus_bridge;
  localparam int DB_W = 16;
  localparam int STR  = 3;
  localparam int HLD  = 2;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0;
  logic [1:0] word = 0;
  logic [DB_W-1:0] wdata = 0, db_in = 0;
  logic [31:0] rdata;
  logic cs_n, rs, wr_n, rd_n, oe;
  logic [DB_W-1:0] db_out;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  lcd_bus_bridge #(.DB_W(DB_W), .STROBE_CLKS(STR), .HOLD_CLKS(HLD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .word_i(word),
    .wdata_i(wdata), .rdata_o(rdata), .cs_no(cs_n), .rs_o(rs), .wr_no(wr_n),
    .rd_no(rd_n), .db_o(db_out), .db_oe_o(oe), .db_i(db_in)
  );

  // bus monitor
  int ev_n = 0, cs_falls = 0;
  logic ev_rd[0:127];
  logic ev_rs[0:127];
  logic [DB_W-1:0] ev_data[0:127];
  int ev_w[0:127], ev_hold[0:127];
  logic ev_setup[0:127];
  logic ev_oe_bad[0:127];
  logic pw = 1, pr = 1, pcs = 1, in_hold = 0, hold_bad = 0, both_low = 0;
  int width = 0, hcnt = 0;
  logic setup_ok = 0, oe_bad = 0;
  logic [DB_W-1:0] d_cur;

  always @(negedge clk) begin
    if (!rst_ni) begin
      pw = 1; pr = 1; pcs = 1;
    end else begin
      if (!wr_n && !rd_n) both_low = 1;
      if (pcs && !cs_n) cs_falls++;
      if (in_hold) begin
        if (!cs_n && wr_n && rd_n) begin
          hcnt++;
          if (!ev_rd[ev_n-1] && (!oe || db_out !== ev_data[ev_n-1])) hold_bad = 1;
        end else begin
          in_hold = 0;
          ev_hold[ev_n-1] = hold_bad ? -1 : hcnt;
        end
      end
      if ((!wr_n && pw) || (!rd_n && pr)) begin
        width = 0; setup_ok = !pcs && pw && pr; oe_bad = 0;
      end
      if (!wr_n || !rd_n) begin
        width++; d_cur = db_out;
        if (!rd_n && oe) oe_bad = 1;
      end
      if ((wr_n && !pw) || (rd_n && !pr)) begin
        ev_rd[ev_n] = !pr; ev_rs[ev_n] = rs; ev_data[ev_n] = d_cur;
        ev_w[ev_n] = width; ev_setup[ev_n] = setup_ok; ev_oe_bad[ev_n] = oe_bad;
        ev_hold[ev_n] = 0;
        ev_n++;
        in_hold = 1; hcnt = 0; hold_bad = 0;
        if (!cs_n) begin
          hcnt = 1;
          if (!pr == 1'b0 && (!oe || db_out !== d_cur)) hold_bad = 1;
        end else begin
          in_hold = 0;
        end
      end
      pw = wr_n; pr = rd_n; pcs = cs_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] w, input logic [DB_W-1:0] d);
    @(negedge clk); req = 1; we = 1; word = w; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic reg_rd(input logic [1:0] w, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; word = w; #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] b;
    for (int i = 0; i < 200; i++) begin
      reg_rd(2'd0, b);
      if (b == 0) return;
    end
    chk(0, "R8 idle timeout", 1, 0);
  endtask

  task automatic check_ev(input int i, input bit rdx, input bit rsx, input logic [DB_W-1:0] dx, input string tag);
    chk(ev_rd[i] == rdx && ev_rs[i] == rsx, {tag, " kind/rs"}, {ev_rd[i], ev_rs[i]}, {rdx, rsx});
    if (!rdx) chk(ev_data[i] == dx, {tag, " data"}, ev_data[i], dx);
    else chk(!ev_oe_bad[i], "R5 oe low during read", ev_oe_bad[i], 0);
    chk(ev_w[i] == STR && ev_setup[i], "R4 strobe width/setup", ev_w[i], STR);
    chk(ev_hold[i] == HLD, "R4 hold window", ev_hold[i], HLD);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int base;
    repeat (3) @(negedge clk);
    chk(cs_n && wr_n && rd_n && !oe, "R1 reset pins", {cs_n, wr_n, rd_n, oe}, 4'b1110);
    rst_ni = 1;
    @(negedge clk);
    reg_rd(2'd0, r); chk(r == 0, "R1 busy after reset", r, 0);
    reg_rd(2'd2, r); chk(r == 0, "R1 flag after reset", r, 0);

    // R2/R3 sweep: walking one and walking zero on both ports
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 2 * DB_W; b++) begin
        logic [DB_W-1:0] v;
        v = (b < DB_W) ? (DB_W'(1) << b) : ~(DB_W'(1) << (b - DB_W));
        base = ev_n;
        reg_wr(p[1:0], v);
        wait_idle();
        chk(ev_n == base + 1, p ? "R3 one cycle" : "R2 one cycle", ev_n - base, 1);
        if (ev_n > base) check_ev(base, 0, p[0], v, p ? "R3" : "R2");
      end

    // R8 busy right after a write
    reg_wr(2'd1, 16'h1234);
    reg_rd(2'd0, r); chk(r == 1, "R8 busy while working", r, 1);
    wait_idle();
    base = ev_n;
    reg_rd(2'd0, r);
    repeat (STR + HLD + 4) @(negedge clk);
    chk(ev_n == base, "R8 busy read starts no cycle", ev_n - base, 0);

    // R5/R6 read sweep
    for (int k = 0; k < 8; k++) begin
      logic [DB_W-1:0] v;
      v = DB_W'(16'hA5C3 ^ (k * 16'h1111));
      reg_wr(2'd2, 0);
      reg_rd(2'd2, r); chk(r == 0, "R7 clear", r, 0);
      db_in = v;
      base = ev_n;
      reg_rd(2'd1, r);
      wait_idle();
      chk(ev_n == base + 1, "R5 one read cycle", ev_n - base, 1);
      if (ev_n > base) check_ev(base, 1, 1, v, "R5");
      reg_rd(2'd2, r); chk(r == 1, "R6 flag set", r, 1);
      reg_rd(2'd1, r); chk(r == {16'h0, v}, "R5 read data", r, v);
      wait_idle();
    end

    // R7 write 1 keeps, write 0 clears
    reg_wr(2'd2, 16'h0001);
    reg_rd(2'd2, r); chk(r == 1, "R7 write one keeps flag", r, 1);
    reg_wr(2'd2, 16'hFFFE);
    reg_rd(2'd2, r); chk(r == 0, "R7 write zero clears", r, 0);

    // R10 unused word
    base = ev_n;
    reg_wr(2'd3, 16'hFFFF);
    reg_rd(2'd3, r); chk(r == 0, "R10 unused reads zero", r, 0);
    repeat (STR + HLD + 4) @(negedge clk);
    chk(ev_n == base, "R10 write starts nothing", ev_n - base, 0);
    reg_rd(2'd2, r); chk(r == 0, "R10 flag untouched", r, 0);

    // R9 burst of three: third is discarded
    base = ev_n;
    cs_falls = 0;
    @(negedge clk); req = 1; we = 1; word = 2'd0; wdata = 16'h00A1;
    @(negedge clk); word = 2'd1; wdata = 16'h00B2;
    @(negedge clk); word = 2'd1; wdata = 16'h00C3;
    @(negedge clk); req = 0; we = 0;
    wait_idle();
    chk(ev_n == base + 2, "R9 third request discarded", ev_n - base, 2);
    chk(cs_falls == 2, "R4 cs high between cycles", cs_falls, 2);
    if (ev_n >= base + 2) begin
      check_ev(base, 0, 0, 16'h00A1, "R9 first");
      check_ev(base + 1, 0, 1, 16'h00B2, "R9 second");
    end
    chk(!both_low, "R4 strobes exclusive", both_low, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule